// File: doc/BRIEF.md
# DRAM Refresh Scheduler with Power-Up Sequencing

This block keeps the contents of an asynchronous DRAM alive and brings the device up after power-on. After reset it holds off for a programmed stabilisation delay. It then runs a burst of dummy refresh cycles and raises an init-done flag. From then on an interval timer adds one owed refresh per period, sized so that every row is refreshed within the retention time. Each refresh is of the internal-counter kind: CAS falls before RAS, so no row address is driven.

The access controller sees a request/grant handshake. The block raises `refReq` while it owes work or is mid-sequence. It starts a sequence only when it samples `refGrant` high, and it owns the strobes until `refReq` drops. When grants are late it keeps count of the refreshes it owes, up to a saturation limit, and raises `refUrgent` once the count passes a threshold. All timings are parameters in clock cycles. At elaboration they are checked against the device minimums for the given clock period.

Top module: `refresh_sched`

## Requirements
- R1: While `rstN` is low, `rasN`, `casN` are 1 and `refReq`, `refUrgent`, `initDone` are 0.
- R2: After reset release, `refReq` first reads high exactly STAB_CYC rising clock edges later, and STAB_CYC × CLK_NS is at least STAB_MIN_NS.
- R3: Exactly DUMMY_CYCLES refresh sequences run before `initDone` rises, and `initDone` stays high until reset.
- R4: Each sequence begins with `casN` low and `rasN` high for exactly CSR_CYC cycles before `rasN` falls.
- R5: After `rasN` falls, `casN` stays low for exactly CHR_CYC cycles and then returns high while `rasN` is still low (CHR_CYC < ACT_CYC).
- R6: `rasN` stays low for exactly ACT_CYC cycles. Both strobes then stay high for at least PRE_CYC cycles before the next `casN` fall, and exactly PRE_CYC cycles when sequences run back to back.
- R7: A sequence starts (`casN` falls) only on the edge after a cycle in which `refGrant` was high. No sequence starts while the grant is withheld.
- R8: Once `refReq` is high, it stays high until the work is done. It is high whenever either strobe is low, and it is low when nothing is owed.
- R9: After `initDone`, one refresh becomes owed every INTERVAL_CYC cycles. Under a continuous grant, consecutive sequence starts are INTERVAL_CYC cycles apart. INTERVAL_CYC × CLK_NS × ROWS must not exceed RETENTION_NS.
- R10: The interval timer adds one to the owed count and each completed refresh removes one. After the grant has been withheld across k intervals (k ≤ OWED_MAX), exactly k sequences follow the grant.
- R11: The owed count saturates at OWED_MAX. With the grant withheld across more intervals than that, exactly OWED_MAX sequences follow.
- R12: `refUrgent` is high exactly when the owed count exceeds URGENT_THR.
- R13: `weLoN`, `weHiN` and `oeN` are 1 at all times.
- R14: The parameters meet the device minimums in nanoseconds: CAS setup 10, CAS hold 15, RAS active 80, RAS precharge 45, RAS high before CAS 10, and a full cycle of 135.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Asynchronous active-low reset |
| refGrant | input | 1 | Bus granted to the refresh scheduler |
| refReq | output | 1 | Refresh requested or in progress |
| refUrgent | output | 1 | Owed count above threshold |
| initDone | output | 1 | Power-up sequence complete |
| rasN | output | 1 | Row strobe, active low |
| casN | output | 1 | Column strobe, active low |
| weLoN | output | 1 | Lower-byte write strobe, held inactive |
| weHiN | output | 1 | Upper-byte write strobe, held inactive |
| oeN | output | 1 | Output enable, held inactive |

## Verification
The bench builds the block with a 40-cycle stabilisation wait and 8 dummy cycles. It uses a 200-cycle refresh interval, an owed limit of 7 and an urgency threshold of 3, with pulse widths of 2, 2, 8 and 5 cycles. These values put the whole power-up phase, several intervals and the saturation of the owed count within a few thousand cycles. A drained backlog of up to seven sequences also fits inside one interval, so the expected count after a late grant is unambiguous. The threshold of 3 puts both sides of the urgency boundary within a short grant hold-off.

// File: rtl/refr_pkg.sv
package refr_pkg;

  // Device minimums in nanoseconds
  localparam int unsigned T_CSR_NS = 10;   // CAS low before RAS falls
  localparam int unsigned T_CHR_NS = 15;   // CAS low after RAS falls
  localparam int unsigned T_RAS_NS = 80;   // RAS active width
  localparam int unsigned T_RP_NS  = 45;   // RAS precharge
  localparam int unsigned T_RPC_NS = 10;   // RAS high before CAS active
  localparam int unsigned T_RC_NS  = 135;  // full cycle

  typedef enum logic [2:0] {
    ST_WAIT,   // power-up stabilisation
    ST_IDLE,
    ST_CSET,   // CAS low, RAS high
    ST_HOLD,   // both low
    ST_ACT,    // RAS low, CAS high
    ST_PRE     // both high, precharge
  } seqState_t;

  typedef enum logic [2:0] {
    LD_NONE,
    LD_CSR,
    LD_CHR,
    LD_ACT,
    LD_PRE
  } tmrLoad_t;

  // Control-to-datapath strobes
  typedef struct packed {
    tmrLoad_t ld;
    logic     seqDone;
    logic     rasLowNxt;
    logic     casLowNxt;
  } seqStrobe_t;

  function automatic int unsigned maxOf(input int unsigned a, input int unsigned b);
    return (a > b) ? a : b;
  endfunction

endpackage

// File: rtl/refr_ctrl.sv
module refr_ctrl
  import refr_pkg::*;
(
  input  logic       clk,
  input  logic       rstN,
  input  logic       refGrant,
  input  logic       tmrZero,
  input  logic       pendNow,
  input  logic       pendAfter,
  output seqStrobe_t stb,
  output logic       refReq
);

  seqState_t st, stNxt;

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) st <= ST_WAIT;
    else       st <= stNxt;
  end

  always_comb begin
    stNxt       = st;
    stb.ld      = LD_NONE;
    stb.seqDone = 1'b0;
    unique case (st)
      ST_WAIT: if (tmrZero) stNxt = ST_IDLE;
      ST_IDLE: if (pendNow && refGrant) begin
        stNxt  = ST_CSET;
        stb.ld = LD_CSR;
      end
      ST_CSET: if (tmrZero) begin
        stNxt  = ST_HOLD;
        stb.ld = LD_CHR;
      end
      ST_HOLD: if (tmrZero) begin
        stNxt  = ST_ACT;
        stb.ld = LD_ACT;
      end
      ST_ACT: if (tmrZero) begin
        stNxt  = ST_PRE;
        stb.ld = LD_PRE;
      end
      ST_PRE: if (tmrZero) begin
        stb.seqDone = 1'b1;
        // back-to-back: precharge already covers RAS-high-before-CAS
        if (pendAfter && refGrant) begin
          stNxt  = ST_CSET;
          stb.ld = LD_CSR;
        end else begin
          stNxt = ST_IDLE;
        end
      end
      default: stNxt = ST_IDLE;
    endcase
    stb.casLowNxt = (stNxt == ST_CSET) || (stNxt == ST_HOLD);
    stb.rasLowNxt = (stNxt == ST_HOLD) || (stNxt == ST_ACT);
  end

  always_comb begin
    refReq = 1'b0;
    unique case (st)
      ST_IDLE:                          refReq = pendNow;
      ST_CSET, ST_HOLD, ST_ACT, ST_PRE: refReq = 1'b1;
      default:                          refReq = 1'b0;
    endcase
  end

  // a request never retracts while waiting for a grant
  AST_REQ_HELD: assert property (@(posedge clk) disable iff (!rstN)
    refReq && !refGrant |=> refReq) else $error("request retracted"); // R8

  // power-up wait is left only via the timer
  AST_WAIT_EXIT: assert property (@(posedge clk) disable iff (!rstN)
    (st == ST_WAIT) && !tmrZero |=> (st == ST_WAIT)) else $error("early exit"); // R2

endmodule

// File: rtl/refr_dpath.sv
module refr_dpath
  import refr_pkg::*;
#(
  parameter int unsigned STAB_CYC     = 20000,
  parameter int unsigned DUMMY_CYCLES = 8,
  parameter int unsigned INTERVAL_CYC = 1560,
  parameter int unsigned CSR_CYC      = 2,
  parameter int unsigned CHR_CYC      = 2,
  parameter int unsigned ACT_CYC      = 8,
  parameter int unsigned PRE_CYC      = 5,
  parameter int unsigned OWED_MAX     = 8,
  parameter int unsigned URGENT_THR   = 4
) (
  input  logic       clk,
  input  logic       rstN,
  input  seqStrobe_t stb,
  output logic       tmrZero,
  output logic       pendNow,
  output logic       pendAfter,
  output logic       initDone,
  output logic       refUrgent,
  output logic       rasN,
  output logic       casN
);

  localparam int unsigned TMR_MAX =
    maxOf(maxOf(STAB_CYC, CSR_CYC), maxOf(maxOf(CHR_CYC, ACT_CYC - CHR_CYC), PRE_CYC));
  localparam int TW = $clog2(TMR_MAX + 1);
  localparam int DW = $clog2(DUMMY_CYCLES + 1);
  localparam int IW = $clog2(INTERVAL_CYC);
  localparam int OW = $clog2(OWED_MAX + 1);

  // ---------------- phase timer ----------------
  logic [TW-1:0] tmr, ldVal;

  always_comb begin
    unique case (stb.ld)
      LD_CSR:  ldVal = TW'(CSR_CYC - 1);
      LD_CHR:  ldVal = TW'(CHR_CYC - 1);
      LD_ACT:  ldVal = TW'(ACT_CYC - CHR_CYC - 1);
      LD_PRE:  ldVal = TW'(PRE_CYC - 1);
      default: ldVal = '0;
    endcase
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN)                  tmr <= TW'(STAB_CYC - 1);
    else if (stb.ld != LD_NONE) tmr <= ldVal;
    else if (tmr != '0)         tmr <= tmr - TW'(1);
  end

  assign tmrZero = (tmr == '0);

  // ---------------- power-up dummy cycles ----------------
  logic [DW-1:0] dumLeft;

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      dumLeft  <= DW'(DUMMY_CYCLES);
      initDone <= 1'b0;
    end else if (stb.seqDone && !initDone) begin
      dumLeft <= dumLeft - DW'(1);
      if (dumLeft == DW'(1)) initDone <= 1'b1;
    end
  end

  // ---------------- interval timer ----------------
  logic [IW-1:0] ivCnt;
  logic          tick;

  assign tick = initDone && (ivCnt == IW'(INTERVAL_CYC - 1));

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN)         ivCnt <= '0;
    else if (tick)     ivCnt <= '0;
    else if (initDone) ivCnt <= ivCnt + IW'(1);
  end

  // ---------------- owed refresh count ----------------
  logic [OW-1:0] owed;
  logic          dec;

  assign dec = stb.seqDone && initDone;

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) owed <= '0;
    else begin
      unique case ({tick, dec})
        2'b10:   if (owed != OW'(OWED_MAX)) owed <= owed + OW'(1);
        2'b01:   if (owed != '0)            owed <= owed - OW'(1);
        default: owed <= owed;
      endcase
    end
  end

  assign pendNow   = initDone ? (owed != '0) : 1'b1;
  assign pendAfter = initDone ? ((owed > OW'(1)) || tick) : (dumLeft > DW'(1));

  generate
    if (URGENT_THR >= OWED_MAX) begin : g_noUrgent
      assign refUrgent = 1'b0;
    end else begin : g_urgent
      assign refUrgent = initDone && (owed > OW'(URGENT_THR));
    end
  endgenerate

  // ---------------- registered strobes ----------------
  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      rasN <= 1'b1;
      casN <= 1'b1;
    end else begin
      rasN <= !stb.rasLowNxt;
      casN <= !stb.casLowNxt;
    end
  end

  AST_OWED_BOUND: assert property (@(posedge clk) disable iff (!rstN)
    owed <= OW'(OWED_MAX)) else $error("owed above limit"); // R11

  AST_OWED_DRAIN: assert property (@(posedge clk) disable iff (!rstN)
    dec && !tick && (owed != '0) |=> owed == $past(owed) - OW'(1))
    else $error("completion not removed from count"); // R10

  AST_CAS_FIRST: assert property (@(posedge clk) disable iff (!rstN)
    $fell(rasN) |-> $past(!casN)) else $error("RAS fell without CAS setup"); // R4

  AST_INIT_STICKY: assert property (@(posedge clk) disable iff (!rstN)
    initDone |=> initDone) else $error("init flag dropped"); // R3

  AST_CAS_IN_ACT: assert property (@(posedge clk) disable iff (!rstN)
    $rose(casN) && !$past(rasN) |-> !rasN) else $error("CAS rose after RAS"); // R5

endmodule

// File: rtl/refresh_sched.sv
module refresh_sched
  import refr_pkg::*;
#(
  parameter int unsigned CLK_NS       = 10,
  parameter int unsigned STAB_CYC     = 20000,
  parameter int unsigned STAB_MIN_NS  = 200000,
  parameter int unsigned DUMMY_CYCLES = 8,
  parameter int unsigned INTERVAL_CYC = 1560,
  parameter int unsigned ROWS         = 256,
  parameter int unsigned RETENTION_NS = 4000000,
  parameter int unsigned CSR_CYC      = 2,
  parameter int unsigned CHR_CYC      = 2,
  parameter int unsigned ACT_CYC      = 8,
  parameter int unsigned PRE_CYC      = 5,
  parameter int unsigned OWED_MAX     = 8,
  parameter int unsigned URGENT_THR   = 4
) (
  input  logic clk,
  input  logic rstN,
  input  logic refGrant,
  output logic refReq,
  output logic refUrgent,
  output logic initDone,
  output logic rasN,
  output logic casN,
  output logic weLoN,
  output logic weHiN,
  output logic oeN
);

  seqStrobe_t stb;
  logic       tmrZero, pendNow, pendAfter;

  refr_ctrl u_ctrl (
    .clk       (clk),
    .rstN      (rstN),
    .refGrant  (refGrant),
    .tmrZero   (tmrZero),
    .pendNow   (pendNow),
    .pendAfter (pendAfter),
    .stb       (stb),
    .refReq    (refReq)
  );

  refr_dpath #(
    .STAB_CYC     (STAB_CYC),
    .DUMMY_CYCLES (DUMMY_CYCLES),
    .INTERVAL_CYC (INTERVAL_CYC),
    .CSR_CYC      (CSR_CYC),
    .CHR_CYC      (CHR_CYC),
    .ACT_CYC      (ACT_CYC),
    .PRE_CYC      (PRE_CYC),
    .OWED_MAX     (OWED_MAX),
    .URGENT_THR   (URGENT_THR)
  ) u_dpath (
    .clk       (clk),
    .rstN      (rstN),
    .stb       (stb),
    .tmrZero   (tmrZero),
    .pendNow   (pendNow),
    .pendAfter (pendAfter),
    .initDone  (initDone),
    .refUrgent (refUrgent),
    .rasN      (rasN),
    .casN      (casN)
  );

  // refresh never writes and never drives data out
  assign weLoN = 1'b1;
  assign weHiN = 1'b1;
  assign oeN   = 1'b1;

  // parameter checks against device minimums
  initial begin
    AST_STAB_WAIT:    assert (longint'(STAB_CYC) * CLK_NS >= longint'(STAB_MIN_NS)) else $error("stabilisation wait too short"); // R2
    AST_DUMMY_MIN:    assert (DUMMY_CYCLES >= 1) else $error("need at least one dummy cycle"); // R3
    AST_CSR_SETUP:    assert (CSR_CYC * CLK_NS >= T_CSR_NS) else $error("CAS setup too short"); // R14
    AST_CHR_HOLD:     assert (CHR_CYC * CLK_NS >= T_CHR_NS) else $error("CAS hold too short"); // R14
    AST_CHR_FITS:     assert (CHR_CYC < ACT_CYC) else $error("CAS hold must end inside RAS active"); // R5
    AST_RAS_ACTIVE:   assert (ACT_CYC * CLK_NS >= T_RAS_NS) else $error("RAS active too short"); // R14
    AST_RAS_PRECH:    assert (PRE_CYC * CLK_NS >= T_RP_NS) else $error("precharge too short"); // R14
    AST_PRECH_TO_CAS: assert (PRE_CYC * CLK_NS >= T_RPC_NS) else $error("RAS high before CAS too short"); // R14
    AST_CYCLE_TIME:   assert ((CSR_CYC + ACT_CYC + PRE_CYC) * CLK_NS >= T_RC_NS) else $error("cycle too short"); // R14
    AST_RETENTION:    assert (longint'(INTERVAL_CYC) * CLK_NS * ROWS <= longint'(RETENTION_NS)) else $error("interval too long"); // R9
    AST_KEEPS_PACE:   assert (INTERVAL_CYC > CSR_CYC + ACT_CYC + PRE_CYC) else $error("interval shorter than a refresh"); // R9
  end

  AST_START_GRANTED: assert property (@(posedge clk) disable iff (!rstN)
    $fell(casN) |-> $past(refGrant)) else $error("refresh started without grant"); // R7

  AST_REQ_COVERS: assert property (@(posedge clk) disable iff (!rstN)
    (!rasN || !casN) |-> refReq) else $error("strobes active without request"); // R8

endmodule

// File: tb/refresh_sched_tb_top.sv
module refresh_sched_tb_top;

  localparam int unsigned CLK_NS = 10;
  localparam int unsigned STAB   = 40;
  localparam int unsigned DUMMY  = 8;
  localparam int unsigned INTV   = 200;
  localparam int unsigned CSR    = 2;
  localparam int unsigned CHR    = 2;
  localparam int unsigned ACT    = 8;
  localparam int unsigned PRE    = 5;
  localparam int unsigned OMAX   = 7;
  localparam int unsigned THR    = 3;

  logic clk = 1'b0;
  logic rstN = 1'b0;
  logic refGrant = 1'b0;
  logic refReq, refUrgent, initDone, rasN, casN, weLoN, weHiN, oeN;

  always #5 clk = ~clk;

  refresh_sched #(
    .CLK_NS(CLK_NS), .STAB_CYC(STAB), .STAB_MIN_NS(400), .DUMMY_CYCLES(DUMMY),
    .INTERVAL_CYC(INTV), .ROWS(256), .RETENTION_NS(600000),
    .CSR_CYC(CSR), .CHR_CYC(CHR), .ACT_CYC(ACT), .PRE_CYC(PRE),
    .OWED_MAX(OMAX), .URGENT_THR(THR)
  ) dut_i (
    .clk(clk), .rstN(rstN), .refGrant(refGrant), .refReq(refReq),
    .refUrgent(refUrgent), .initDone(initDone), .rasN(rasN), .casN(casN),
    .weLoN(weLoN), .weHiN(weHiN), .oeN(oeN)
  );

  int nChecks = 0;
  int nFails  = 0;
  bit finished = 0;

  task automatic check(input bit ok, input string req, input string what,
                       input longint act, input longint exp);
    nChecks++;
    if (!ok) begin
      nFails++;
      $display("FAIL %s %s: actual %0d expected %0d", req, what, act, exp);
    end
  endtask

  function automatic int expOwed(input int k);
    return (k > int'(OMAX)) ? int'(OMAX) : k;
  endfunction

  // ---------------- pin monitor ----------------
  longint cycNow = 0, lastStart = 0, startGap = 0;
  int startCnt = 0, weBad = 0, reqDrop = 0;
  int csr = 0, hold = 0, act = 0, gap = 0;
  bit prevRas = 1, prevCas = 1, prevGrant = 0, holding = 0, seenRise = 0;

  always @(negedge clk) begin
    cycNow++;
    if (!rstN) begin
      prevRas = 1; prevCas = 1; prevGrant = refGrant;
    end else begin
      if (!weLoN || !weHiN || !oeN) weBad++;
      if ((!rasN || !casN) && !refReq) reqDrop++;
      if (prevCas && !casN && rasN) begin
        startCnt++;
        startGap  = cycNow - lastStart;
        lastStart = cycNow;
        check(prevGrant, "R7", "start without grant", 0, 1);
        if (seenRise) begin
          check(gap >= int'(PRE), "R6", "precharge gap", gap, PRE);
          check(startGap * CLK_NS >= 135, "R14", "cycle time ns", startGap * CLK_NS, 135);
        end
        csr = 1;
      end else if (!casN && rasN) csr++;
      if (prevRas && !rasN) begin
        check(csr == int'(CSR) && !casN, "R4", "CAS setup cycles", csr, CSR);
        hold = 1; act = 1; holding = 1;
      end else if (!rasN) begin
        act++;
        if (!casN && holding) hold++;
        else holding = 0;
      end
      if (!prevRas && rasN) begin
        check(act == int'(ACT), "R6", "RAS active cycles", act, ACT);
        check(hold == int'(CHR), "R5", "CAS hold cycles", hold, CHR);
        check(act * CLK_NS >= 80 && hold * CLK_NS >= 15 && csr * CLK_NS >= 10,
              "R14", "pulse widths ns", act * CLK_NS, 80);
        gap = 1; seenRise = 1;
      end else if (rasN && casN) gap++;
      prevRas = rasN; prevCas = casN; prevGrant = refGrant;
    end
  end

  task automatic smp();
    @(negedge clk); #1;
  endtask

  task automatic drv();
    @(posedge clk); #2;
  endtask

  task automatic waitReq(input bit lvl);
    int n = 0;
    while (refReq !== lvl && n < 5000) begin smp(); n++; end
  endtask

  task automatic trial(input int k);
    int s0, e, n;
    waitReq(1'b0);
    drv(); refGrant = 1'b0;
    s0 = startCnt;
    smp();
    waitReq(1'b1);
    repeat ((k - 1) * int'(INTV) + 20) smp();
    e = expOwed(k);
    check(refUrgent == (e > int'(THR)), "R12", $sformatf("urgent k=%0d", k), refUrgent, e > int'(THR));
    check(refReq == 1'b1, "R8", "request held while waiting", refReq, 1);
    check(startCnt == s0, "R7", "starts while grant withheld", startCnt - s0, 0);
    drv(); refGrant = 1'b1;
    smp();
    n = 0;
    while (refReq && n < 2000) begin smp(); n++; end
    check(startCnt - s0 == e, (k > int'(OMAX)) ? "R11" : "R10",
          $sformatf("sequences after hold-off k=%0d", k), startCnt - s0, e);
    check(refUrgent == 1'b0, "R12", "urgent after drain", refUrgent, 0);
  endtask

  task automatic summary();
    if (!finished) begin
      finished = 1;
      check(weBad == 0, "R13", "write/output strobes active", weBad, 0);
      check(reqDrop == 0, "R8", "strobes active without request", reqDrop, 0);
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", nChecks, nFails);
      $finish;
    end
  endtask

  // watchdog
  initial begin
    repeat (150000) @(posedge clk);
    nChecks++; nFails++;
    $display("FAIL watchdog: actual %0d expected %0d", 150000, 0);
    summary();
  end

  initial begin
    int n, s;
    void'($urandom(32'd1234));
    // R1 reset state
    repeat (3) smp();
    check(rasN && casN, "R1", "strobes in reset", {rasN, casN}, 3);
    check(!refReq && !refUrgent && !initDone, "R1", "flags in reset",
          {refReq, refUrgent, initDone}, 0);
    refGrant = 1'b1;
    drv(); rstN = 1'b1;
    // R2 stabilisation wait
    n = 0;
    do begin @(posedge clk); n++; smp(); end while (!refReq && n < 1000);
    check(n == int'(STAB), "R2", "edges until first request", n, STAB);
    check(initDone == 1'b0, "R2", "init flag during wait", initDone, 0);
    // R3 dummy burst
    n = 0;
    while (!initDone && n < 2000) begin smp(); n++; end
    check(startCnt == int'(DUMMY), "R3", "dummy sequences", startCnt, DUMMY);
    check(refReq == 1'b0, "R8", "request drops after init", refReq, 1'b0);
    // R9 steady interval under continuous grant
    s = startCnt;
    for (int i = 1; i <= 4; i++) begin
      n = 0;
      while (startCnt < s + i && n < 1000) begin smp(); n++; end
      if (i > 1) check(startGap == INTV, "R9", "start spacing", startGap, INTV);
    end
    // directed backlog corners, then random
    trial(3);
    trial(4);
    trial(12);
    for (int t = 0; t < 8; t++) trial(1 + int'($urandom % 10));
    check(initDone == 1'b1, "R3", "init flag stays high", initDone, 1);
    summary();
  end

endmodule